// File: doc/BRIEF.md
# DDR Mode and Extended-Mode Register Capture

This block watches the sampled command pins of a low-power DDR memory and keeps a shadow copy of the two configuration registers such a device holds. It can sit in a memory model or beside a controller. A register-write command loads either the base register or the extended register. The bank-address bits pick which one. The fields come from the address bus. The block presents the decoded fields as plain values: burst length, burst ordering, read latency, the refreshed portion of the array, and output drive strength.

Each write is checked before it takes effect. The banks must all be idle. Every field code must be defined, and every unused address bit must be zero. A write that fails any of these checks leaves both registers unchanged and raises a one-cycle error. An accepted write starts a short lockout. During the lockout any command other than a no-operation is flagged as an error and is discarded. A legal base-register write also returns the extended register to its power-on default.

Top module: `lpddr_mode_regs`

## Requirements
- R1: A register write is decoded at a rising clock edge where cs_n, ras_n, cas_n and we_n are all low. ba=00 selects the base register and ba=10 selects the extended register. A write with ba=01 or ba=11 is rejected with an error. Other commands, such as a read (cs_n=0, ras_n=1, cas_n=0, we_n=1), change nothing and raise no error.
- R2: In a base write, addr[2:0] gives the burst length: 001 gives 2, 010 gives 4, 011 gives 8 and 100 gives 16, and burst_len carries that number. addr[3] gives the burst ordering, with 1 meaning interleaved. addr[6:4] gives the read latency: 010 gives 2 and 011 gives 3, and cas_lat carries that number.
- R3: A base write with an undefined burst-length code or an undefined latency code is rejected. The register keeps its value, mr_error is raised, and mr_busy is not set.
- R4: A write with any reserved address bit set is rejected with an error. For the base register the reserved bits are addr[12:7]. For the extended register they are addr[12:7], addr[4] and addr[3].
- R5: In an extended write, addr[2:0] selects the refreshed area, and pasr_area carries the code: 000 is full (0), 001 is half (1) and 010 is quarter (2). The other area codes are rejected with an error. addr[6:5] selects the drive strength, and drv_strength carries the code: 0 is full, 1 is half, 2 is quarter and 3 is one-eighth.
- R6: After reset the extended register reads pasr_area=0 (full) and drv_strength=1 (half).
- R7: A legal base write also puts the extended register back to pasr_area=0 and drv_strength=1.
- R8: A register write made while banks_idle is low is rejected with an error, and both registers keep their values.
- R9: mode_valid stays low after reset, and burst_len and cas_lat read 0, until the first legal base write. After that write mode_valid stays high.
- R10: mr_busy is high for exactly the two cycles after an accepted write. A rejected write does not set it.
- R11: Any command other than a no-operation that is sampled while mr_busy is high raises mr_error and has no effect. A no-operation is cs_n=1, or ras_n, cas_n and we_n all high.
- R12: mr_error is registered. It is high in the cycle after the edge where the offending command was sampled, and it goes low again after one cycle unless another offence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin, active low |
| cas_n | input | 1 | Column strobe command pin, active low |
| we_n | input | 1 | Write-enable command pin, active low |
| ba | input | 2 | Bank address; selects the register for a write |
| addr | input | 13 | Address bus carrying the register fields |
| banks_idle | input | 1 | High when every bank is precharged |
| burst_len | output | 5 | Burst length in beats (0 until configured) |
| burst_interleave | output | 1 | 1 = interleaved burst ordering, 0 = sequential |
| cas_lat | output | 2 | Read latency in cycles (0 until configured) |
| mode_valid | output | 1 | Base register has been loaded at least once |
| pasr_area | output | 2 | Refreshed area code: 0 full, 1 half, 2 quarter |
| drv_strength | output | 2 | Drive strength code: 0 full, 1 half, 2 quarter, 3 eighth |
| mr_error | output | 1 | One-cycle pulse for a rejected or ill-timed command |
| mr_busy | output | 1 | Lockout window after an accepted write |

## Verification
The assertions assume that the command pins, ba, addr and banks_idle carry known values at every sampled edge after reset. They also assume that banks_idle is driven by the surrounding logic and is not derived from this block. The stimulus changes every input on the falling edge only. It returns the pins to a no-operation after each command. It holds banks_idle high except in the one case that tests rejection when the banks are not idle. Deliberate commands inside the lockout are placed on the first and second edges after a write. Every other write waits until the lockout has ended.

// File: rtl/lpddr_mr_pkg.sv
package lpddr_mr_pkg;

  // Decoded base configuration
  typedef struct packed {
    logic [4:0] burst_len;
    logic       interleave;
    logic [1:0] cas_lat;
  } base_cfg_t;

  // Decoded extended configuration
  typedef struct packed {
    logic [1:0] pasr;
    logic [1:0] drv;
  } ext_cfg_t;

  localparam base_cfg_t BASE_RESET  = '{burst_len: 5'd0, interleave: 1'b0, cas_lat: 2'd0};
  localparam ext_cfg_t  EXT_DEFAULT = '{pasr: 2'd0, drv: 2'd1};

  localparam logic [1:0] SEL_BASE = 2'b00;
  localparam logic [1:0] SEL_EXT  = 2'b10;

  // {legal, beats}
  function automatic logic [5:0] decode_burst(input logic [2:0] code);
    case (code)
      3'b001:  decode_burst = {1'b1, 5'd2};
      3'b010:  decode_burst = {1'b1, 5'd4};
      3'b011:  decode_burst = {1'b1, 5'd8};
      3'b100:  decode_burst = {1'b1, 5'd16};
      default: decode_burst = {1'b0, 5'd0};
    endcase
  endfunction

  // {legal, latency}
  function automatic logic [2:0] decode_latency(input logic [2:0] code);
    case (code)
      3'b010:  decode_latency = {1'b1, 2'd2};
      3'b011:  decode_latency = {1'b1, 2'd3};
      default: decode_latency = {1'b0, 2'd0};
    endcase
  endfunction

endpackage

// File: rtl/lpddr_mr_decode.sv
module lpddr_mr_decode
  import lpddr_mr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              busy,
  output logic              base_we,
  output logic              ext_we,
  output base_cfg_t         base_d,
  output ext_cfg_t          ext_d,
  output logic              err_set
);

  localparam int FIELD_W = 7;
  localparam logic [ADDR_W-1:0] BASE_RSV = {ADDR_W{1'b1}} << FIELD_W;
  localparam logic [ADDR_W-1:0] EXT_RSV  = BASE_RSV | ADDR_W'(7'b0011000);

  logic       is_write;
  logic       is_nop;
  logic [5:0] bl_dec;
  logic [2:0] cl_dec;
  logic       pasr_ok;
  logic       base_ok;
  logic       ext_ok;

  always_comb begin
    is_write = !cs_n && !ras_n && !cas_n && !we_n;
    is_nop   = cs_n || (ras_n && cas_n && we_n);

    bl_dec   = decode_burst(addr[2:0]);
    cl_dec   = decode_latency(addr[6:4]);
    pasr_ok  = (addr[2:0] <= 3'd2);

    base_d.burst_len  = bl_dec[4:0];
    base_d.interleave = addr[3];
    base_d.cas_lat    = cl_dec[1:0];
    ext_d.pasr        = addr[1:0];
    ext_d.drv         = addr[6:5];

    base_ok = is_write && !busy && banks_idle && (ba == SEL_BASE) &&
              bl_dec[5] && cl_dec[2] && ((addr & BASE_RSV) == '0);
    ext_ok  = is_write && !busy && banks_idle && (ba == SEL_EXT) &&
              pasr_ok && ((addr & EXT_RSV) == '0);

    base_we = base_ok;
    ext_we  = ext_ok;
    err_set = (busy && !is_nop) || (is_write && !busy && !base_ok && !ext_ok);
  end

endmodule

// File: rtl/lpddr_mr_lock.sv
module lpddr_mr_lock #(
  parameter int LOCK_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = CNT_W'(LOCK_CYCLES);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R10
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R10
  busy_only_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/lpddr_mr_base_reg.sv
module lpddr_mr_base_reg
  import lpddr_mr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  base_cfg_t d,
  output base_cfg_t q,
  output logic      valid
);

  base_cfg_t cfg_q;
  logic      valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= BASE_RESET;
      valid_q <= 1'b0;
    end else if (we) begin
      cfg_q   <= d;
      valid_q <= 1'b1;
    end
  end

  assign q     = cfg_q;
  assign valid = valid_q;

  // R3
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

  // R2
  latency_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (q.cas_lat == 2'd2 || q.cas_lat == 2'd3));

endmodule

// File: rtl/lpddr_mr_ext_reg.sv
module lpddr_mr_ext_reg
  import lpddr_mr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  logic     clr,
  input  ext_cfg_t d,
  output ext_cfg_t q
);

  ext_cfg_t cfg_q;
  ext_cfg_t cfg_d;
  logic     cfg_en;

  always_comb begin
    cfg_en = we || clr;
    cfg_d  = clr ? EXT_DEFAULT : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= EXT_DEFAULT;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign q = cfg_q;

  // R7
  ext_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == EXT_DEFAULT));

  // R5
  ext_area_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q.pasr != 2'd3);

endmodule

// File: rtl/lpddr_mode_regs.sv
module lpddr_mode_regs
  import lpddr_mr_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int LOCK_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic [4:0]        burst_len,
  output logic              burst_interleave,
  output logic [1:0]        cas_lat,
  output logic              mode_valid,
  output logic [1:0]        pasr_area,
  output logic [1:0]        drv_strength,
  output logic              mr_error,
  output logic              mr_busy
);

  logic      base_we;
  logic      ext_we;
  logic      err_set;
  logic      busy;
  base_cfg_t base_d;
  base_cfg_t base_q;
  ext_cfg_t  ext_d;
  ext_cfg_t  ext_q;
  logic      err_q;
  logic      err_d;

  lpddr_mr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr       (addr),
    .banks_idle (banks_idle),
    .busy       (busy),
    .base_we    (base_we),
    .ext_we     (ext_we),
    .base_d     (base_d),
    .ext_d      (ext_d),
    .err_set    (err_set)
  );

  lpddr_mr_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .start (base_we || ext_we),
    .busy  (busy)
  );

  lpddr_mr_base_reg u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (base_we),
    .d     (base_d),
    .q     (base_q),
    .valid (mode_valid)
  );

  lpddr_mr_ext_reg u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ext_we),
    .clr   (base_we),
    .d     (ext_d),
    .q     (ext_q)
  );

  always_comb err_d = err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign burst_len        = base_q.burst_len;
  assign burst_interleave = base_q.interleave;
  assign cas_lat          = base_q.cas_lat;
  assign pasr_area        = ext_q.pasr;
  assign drv_strength     = ext_q.drv;
  assign mr_error         = err_q;
  assign mr_busy          = busy;

  // R8
  idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && !we_n && !banks_idle) |=> mr_error);

  // R11
  busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_busy && !cs_n && !(ras_n && cas_n && we_n)) |=> mr_error);

  // R11
  busy_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr_busy |=> ($stable(burst_len) && $stable(pasr_area) && $stable(drv_strength)));

endmodule

// File: tb/lpddr_mode_regs_tb.sv
module lpddr_mode_regs_tb;

  logic        clk;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        banks_idle;
  logic [4:0]  burst_len;
  logic        burst_interleave;
  logic [1:0]  cas_lat;
  logic        mode_valid;
  logic [1:0]  pasr_area;
  logic [1:0]  drv_strength;
  logic        mr_error;
  logic        mr_busy;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  lpddr_mode_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .burst_len(burst_len), .burst_interleave(burst_interleave), .cas_lat(cas_lat),
    .mode_valid(mode_valid), .pasr_area(pasr_area), .drv_strength(drv_strength),
    .mr_error(mr_error), .mr_busy(mr_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nop_pins();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = 2'b00; addr = '0; banks_idle = 1'b1;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic cmd(input logic c, input logic r, input logic ca, input logic w,
                     input logic [1:0] b, input logic [12:0] a, input logic idle);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a; banks_idle = idle;
    @(posedge clk);
    @(negedge clk);
    nop_pins();
  endtask

  task automatic mrw(input logic [1:0] b, input logic [12:0] a);
    cmd(1'b0, 1'b0, 1'b0, 1'b0, b, a, 1'b1);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 valid after reset", mode_valid, 0);
    chk("R9 burst_len after reset", burst_len, 0);
    chk("R9 cas_lat after reset", cas_lat, 0);
    chk("R6 pasr default", pasr_area, 0);
    chk("R6 drive default", drv_strength, 1);
    chk("R10 busy after reset", mr_busy, 0);
    chk("R12 error after reset", mr_error, 0);
  endtask

  task automatic t_invalid_first();
    mrw(2'b00, 13'h030);
    chk("R3 reserved burst code error", mr_error, 1);
    chk("R9 valid stays low", mode_valid, 0);
    chk("R10 no busy on reject", mr_busy, 0);
    gap(1);
    chk("R12 error one cycle", mr_error, 0);
  endtask

  task automatic t_base_basic();
    mrw(2'b00, 13'h032);
    chk("R2 burst 4", burst_len, 4);
    chk("R2 sequential", burst_interleave, 0);
    chk("R2 latency 3", cas_lat, 3);
    chk("R9 valid set", mode_valid, 1);
    chk("R10 busy cycle 1", mr_busy, 1);
    chk("R1 no error", mr_error, 0);
    gap(1);
    chk("R10 busy cycle 2", mr_busy, 1);
    gap(1);
    chk("R10 busy ends", mr_busy, 0);
  endtask

  task automatic t_ext();
    mrw(2'b10, 13'h041);
    chk("R5 pasr half", pasr_area, 1);
    chk("R5 drive quarter", drv_strength, 2);
    chk("R5 no error", mr_error, 0);
    gap(2);
    mrw(2'b10, 13'h062);
    chk("R5 pasr quarter", pasr_area, 2);
    chk("R5 drive eighth", drv_strength, 3);
    gap(2);
  endtask

  task automatic t_base_clears_ext();
    mrw(2'b00, 13'h02C);
    chk("R2 burst 16", burst_len, 16);
    chk("R2 interleave", burst_interleave, 1);
    chk("R2 latency 2", cas_lat, 2);
    chk("R7 pasr back to full", pasr_area, 0);
    chk("R7 drive back to half", drv_strength, 1);
    gap(2);
  endtask

  task automatic t_burst_codes();
    for (int code = 1; code <= 4; code++) begin
      mrw(2'b00, 13'h030 | 13'(code));
      chk("R2 burst code", burst_len, 1 << code);
      gap(2);
    end
  endtask

  task automatic t_reserved_codes();
    mrw(2'b00, 13'h035);
    chk("R3 burst 101 error", mr_error, 1);
    chk("R3 burst unchanged", burst_len, 16);
    chk("R3 no busy", mr_busy, 0);
    gap(1);
    mrw(2'b00, 13'h014);
    chk("R3 latency 001 error", mr_error, 1);
    chk("R3 latency unchanged", cas_lat, 3);
    gap(1);
    chk("R12 error cleared", mr_error, 0);
  endtask

  task automatic t_reserved_bits();
    mrw(2'b00, 13'h0B2);
    chk("R4 base A7 error", mr_error, 1);
    chk("R4 base unchanged", burst_len, 16);
    gap(1);
    mrw(2'b10, 13'h009);
    chk("R4 ext A3 error", mr_error, 1);
    chk("R4 ext unchanged", pasr_area, 0);
    gap(1);
    mrw(2'b10, 13'h1001);
    chk("R4 ext A12 error", mr_error, 1);
    gap(1);
    mrw(2'b10, 13'h003);
    chk("R5 pasr 011 error", mr_error, 1);
    chk("R5 pasr unchanged", pasr_area, 0);
    gap(1);
  endtask

  task automatic t_bank_select();
    mrw(2'b01, 13'h032);
    chk("R1 ba 01 error", mr_error, 1);
    gap(1);
    mrw(2'b11, 13'h032);
    chk("R1 ba 11 error", mr_error, 1);
    chk("R1 burst unchanged", burst_len, 16);
    gap(1);
    cmd(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 13'h032, 1'b1);
    chk("R1 read no error", mr_error, 0);
    chk("R1 read no change", burst_len, 16);
  endtask

  task automatic t_not_idle();
    cmd(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 13'h032, 1'b0);
    chk("R8 not idle error", mr_error, 1);
    chk("R8 burst unchanged", burst_len, 16);
    chk("R8 no busy", mr_busy, 0);
    gap(1);
  endtask

  task automatic t_busy_window();
    mrw(2'b10, 13'h021);
    chk("R5 pasr half drive half", pasr_area, 1);
    cmd(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 13'h000, 1'b1);
    chk("R11 activate in lockout error", mr_error, 1);
    chk("R10 still busy", mr_busy, 1);
    mrw(2'b10, 13'h042);
    chk("R11 write in lockout error", mr_error, 1);
    chk("R11 pasr not applied", pasr_area, 1);
    chk("R11 drive not applied", drv_strength, 1);
    chk("R10 busy over", mr_busy, 0);
    gap(1);
    chk("R12 error cleared", mr_error, 0);
    cmd(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 13'h000, 1'b1);
    chk("R11 read after lockout ok", mr_error, 0);
    mrw(2'b10, 13'h000);
    gap(1);
    chk("R11 nop in lockout ok", mr_error, 0);
    gap(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    nop_pins();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid_first();
    t_base_basic();
    t_ext();
    t_base_clears_ext();
    t_burst_codes();
    t_reserved_codes();
    t_reserved_bits();
    t_bank_select();
    t_not_idle();
    t_busy_window();
    finish_run();
  end

endmodule